// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A global history register holds the outcomes of the most recently resolved branches. A table of 2-bit saturating counters is organised in rows. Some of the fetch PC's bits select a row, and the global history selects one counter within that row. The prediction is the upper bit of the selected counter.

The front end sends lookup requests on a valid/ready stream. Each accepted request produces one registered response that carries the prediction and the history value used to make it. The front end keeps that history with the branch. When the branch resolves, in program order, the back end returns the PC, the real outcome and the saved history on the resolve port. The outcome is shifted into the global history, and the counter selected by the saved history is trained.

On the lookup stream, a request transfers when `lk_valid` and `lk_ready` are both high at a rising edge. The response is held unchanged while `pr_valid` is high and `pr_ready` is low. A new request is accepted only when the response register is empty or is being drained in the same cycle. The resolve port never stalls.

Top module: `glh_predictor`

## Requirements
- R1: After reset the global history is all zeros and every counter holds 01 (weakly not-taken), so the first lookup to any PC returns not-taken with history 0.
- R2: An accepted lookup produces a response in the next cycle. `pr_taken` is bit 1 of the counter at row `pc[IDX_W+1:2]` and set equal to the global history value at acceptance, and `pr_hist` is that history value.
- R3: PC bits [1:0] and the PC bits above bit IDX_W+1 have no effect on the prediction.
- R4: A resolve shifts `rs_taken` into bit 0 of the history: new history = {old history[HIST_W-2:0], rs_taken}.
- R5: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken resolve increments the counter and saturates at 11. A not-taken resolve decrements it and saturates at 00.
- R6: Training uses `rs_hist` as the set selector, not the current history. Other sets and other rows are left unchanged.
- R7: While `pr_valid` is high and `pr_ready` is low, `pr_valid`, `pr_taken` and `pr_hist` stay stable, and `lk_ready` is low.
- R8: When a lookup and a resolve happen in the same cycle, the lookup sees the history and counters as they were before that resolve.
- R9: `rs_ready` is high in every cycle after reset. Every resolve with `rs_valid` high is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | PC_W | Fetch PC of the lookup |
| pr_valid | output | 1 | Prediction response valid |
| pr_ready | input | 1 | Consumer accepts the response |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_hist | output | HIST_W | History used for this prediction |
| rs_valid | input | 1 | Resolve update valid |
| rs_ready | output | 1 | Resolve accepted (always high) |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_hist | input | HIST_W | History that was returned with this branch's prediction |

## Verification
The assertions check several properties in every cycle:
- the history shift rule after each resolve;
- the one-cycle lookup-to-response timing;
- that a response only appears after an accepted request;
- that a stalled response stays stable;
- that the history is zero on leaving reset.

The counter contents cannot be seen from a single cycle of port activity. Saturation, selection by the saved history, PC bit aliasing and same-cycle ordering are therefore shown only by the bench scenarios. The bench compares every prediction against its own model of the table.

// File: rtl/glh_pkg.sv
package glh_pkg;
  // 2-bit direction counter; the upper bit is the prediction
  typedef enum logic [1:0] {
    CNT_STRONG_NT = 2'b00,
    CNT_WEAK_NT   = 2'b01,
    CNT_WEAK_T    = 2'b10,
    CNT_STRONG_T  = 2'b11
  } cnt_t;

  localparam cnt_t CNT_RESET = CNT_WEAK_NT;

  // saturating step toward the resolved direction
  function automatic cnt_t cnt_step(input cnt_t cur, input logic taken);
    cnt_t nxt;
    if (taken) nxt = (cur == CNT_STRONG_T)  ? cur : cnt_t'(cur + 2'd1);
    else       nxt = (cur == CNT_STRONG_NT) ? cur : cnt_t'(cur - 2'd1);
    return nxt;
  endfunction
endpackage

// File: rtl/glh_history.sv
module glh_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= HIST_W'({hist_q, shift_bit});
  end

  assign hist = hist_q;
endmodule

// File: rtl/glh_counter_bank.sv
module glh_counter_bank
  import glh_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_row,
  input  logic [HIST_W-1:0] rd_set,
  output cnt_t              rd_cnt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [HIST_W-1:0] wr_set,
  input  logic              wr_taken
);
  localparam int ADDR_W  = IDX_W + HIST_W;
  localparam int ENTRIES = 1 << ADDR_W;

  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  cnt_t              cnt_w [ENTRIES];

  assign rd_addr = {rd_row, rd_set};
  assign wr_addr = {wr_row, wr_set};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    cnt_t c_q;
    always_ff @(posedge clk) begin
      if (rst)                                     c_q <= CNT_RESET;
      else if (wr_en && (wr_addr == ADDR_W'(e)))   c_q <= cnt_step(c_q, wr_taken);
    end
    assign cnt_w[e] = c_q;
  end

  assign rd_cnt = cnt_w[rd_addr];
endmodule

// File: rtl/glh_resp_stage.sv
module glh_resp_stage #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_taken,
  input  logic [HIST_W-1:0] in_hist,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [HIST_W-1:0] out_hist
);
  logic              v_q;
  logic              t_q;
  logic [HIST_W-1:0] h_q;
  logic              load;

  assign in_ready = !v_q || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)            v_q <= 1'b0;
    else if (load)      v_q <= 1'b1;
    else if (out_ready) v_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= 1'b0;
      h_q <= '0;
    end else if (load) begin
      t_q <= in_taken;
      h_q <= in_hist;
    end
  end

  assign out_valid = v_q;
  assign out_taken = t_q;
  assign out_hist  = h_q;
endmodule

// File: rtl/glh_predictor.sv
module glh_predictor
  import glh_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pr_valid,
  input  logic              pr_ready,
  output logic              pr_taken,
  output logic [HIST_W-1:0] pr_hist,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_taken,
  input  logic [HIST_W-1:0] rs_hist
);
  localparam int ROW_LO = 2;
  localparam int ROW_HI = ROW_LO + IDX_W - 1;

  logic [HIST_W-1:0] ghr_q;
  cnt_t              rd_cnt;
  logic              rs_fire;

  assign rs_ready = !rst;
  assign rs_fire  = rs_valid && rs_ready;

  glh_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (rs_fire),
    .shift_bit (rs_taken),
    .hist      (ghr_q)
  );

  glh_counter_bank #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .rd_row   (lk_pc[ROW_HI:ROW_LO]),
    .rd_set   (ghr_q),
    .rd_cnt   (rd_cnt),
    .wr_en    (rs_fire),
    .wr_row   (rs_pc[ROW_HI:ROW_LO]),
    .wr_set   (rs_hist),
    .wr_taken (rs_taken)
  );

  glh_resp_stage #(.HIST_W(HIST_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (lk_valid),
    .in_ready  (lk_ready),
    .in_taken  (rd_cnt[1]),
    .in_hist   (ghr_q),
    .out_valid (pr_valid),
    .out_ready (pr_ready),
    .out_taken (pr_taken),
    .out_hist  (pr_hist)
  );
endmodule

// File: rtl/glh_checker.sv
module glh_checker #(
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              pr_valid,
  input logic              pr_ready,
  input logic              pr_taken,
  input logic [HIST_W-1:0] pr_hist,
  input logic              rs_valid,
  input logic              rs_taken,
  input logic [HIST_W-1:0] ghr
);
  // R1
  hist_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ghr == '0));

  // R4
  hist_shift_rule_chk: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> (ghr == HIST_W'({$past(ghr), $past(rs_taken)})));

  // R2
  resp_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> pr_valid);

  // R2
  resp_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pr_valid) |-> $past(lk_valid && lk_ready));

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && !pr_ready) |=> (pr_valid && $stable(pr_taken) && $stable(pr_hist)));
endmodule

bind glh_predictor glh_checker #(.HIST_W(HIST_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .pr_valid (pr_valid),
  .pr_ready (pr_ready),
  .pr_taken (pr_taken),
  .pr_hist  (pr_hist),
  .rs_valid (rs_valid),
  .rs_taken (rs_taken),
  .ghr      (ghr_q)
);

// File: tb/sim_glh_predictor.sv
module sim_glh_predictor;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 2;
  localparam int ROWS   = 1 << IDX_W;
  localparam int SETS   = 1 << HIST_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, lk_ready, pr_valid, pr_ready = 1'b0, pr_taken;
  logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
  logic [HIST_W-1:0] pr_hist, rs_hist = '0;
  logic rs_valid = 1'b0, rs_ready, rs_taken = 1'b0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0]        m_cnt [ROWS][SETS];
  logic [HIST_W-1:0] m_ghr;
  logic              m_v, m_t;
  logic [HIST_W-1:0] m_h;
  string             m_tag;

  always #4 clk = ~clk;

  glh_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken), .pr_hist(pr_hist),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_hist(rs_hist)
  );

  function automatic int row_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < SETS; s++) m_cnt[r][s] = 2'b01;
    m_ghr = '0; m_v = 1'b0; m_t = 1'b0; m_h = '0; m_tag = "R1";
  endtask

  // one cycle: drive at negedge, update model, check after the edge
  task automatic step(input bit lv, input logic [PC_W-1:0] lpc, input bit prdy,
                      input bit rv, input logic [PC_W-1:0] rpc, input bit rt,
                      input logic [HIST_W-1:0] rh);
    bit exp_rdy, fire;
    logic [1:0] c;
    lk_valid = lv; lk_pc = lpc; pr_ready = prdy;
    rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_hist = rh;
    #1;
    exp_rdy = !m_v || prdy;
    check(lk_ready == exp_rdy, "R7", int'(lk_ready), int'(exp_rdy));
    check(rs_ready == 1'b1, "R9", int'(rs_ready), 1);
    fire = lv && exp_rdy;
    if (fire) begin
      c = m_cnt[row_of(lpc)][m_ghr];
      m_v = 1'b1; m_t = c[1]; m_h = m_ghr;
      if (rv) m_tag = "R8";
      else if (c == 2'b00 || c == 2'b11) m_tag = "R5";
      else if (m_ghr != '0) m_tag = "R6";
      else if (lpc[1:0] != 2'b00 || lpc[PC_W-1:IDX_W+2] != '0) m_tag = "R3";
      else m_tag = "R2";
    end else if (prdy) begin
      m_v = 1'b0;
    end else if (m_v) begin
      m_tag = "R7";
    end
    if (rv) begin
      m_cnt[row_of(rpc)][rh] = sat(m_cnt[row_of(rpc)][rh], rt);
      m_ghr = HIST_W'({m_ghr, rt});
    end
    @(posedge clk);
    @(negedge clk);
    check(pr_valid == m_v, m_tag, int'(pr_valid), int'(m_v));
    if (m_v) begin
      check(pr_taken == m_t, m_tag, int'(pr_taken), int'(m_t));
      check(pr_hist == m_h, (m_tag == "R2") ? "R4" : m_tag, int'(pr_hist), int'(m_h));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle state after reset
    check(pr_valid == 1'b0, "R1", int'(pr_valid), 0);
    check(lk_ready == 1'b1, "R1", int'(lk_ready), 1);
    // R1: first lookup is weakly not-taken with zero history
    step(1, 32'h0000_1000, 1, 0, '0, 0, '0);
    check(pr_taken == 1'b0 && pr_hist == '0, "R1", int'(pr_taken), 0);
    // R5: saturate one counter upward, then downward
    for (int i = 0; i < 4; i++) step(0, '0, 1, 1, 32'h40, 1, 2'd3);
    step(1, 32'h40, 1, 0, '0, 0, '0);                 // ghr now 11 -> set 3
    for (int i = 0; i < 5; i++) step(0, '0, 1, 1, 32'h40, 0, 2'd3);
    step(0, '0, 1, 1, 32'h0, 1, 2'd0);
    step(0, '0, 1, 1, 32'h0, 1, 2'd0);
    step(1, 32'h40, 1, 0, '0, 0, '0);
    // R6: train set 2 of row 5 only, look up under other history values
    for (int i = 0; i < 2; i++) step(0, '0, 1, 1, 32'h14, 1, 2'd2);
    step(0, '0, 1, 1, 32'h0, 1, 2'd0);
    step(0, '0, 1, 1, 32'h0, 0, 2'd0);                // ghr = 10
    step(1, 32'h14, 1, 0, '0, 0, '0);
    step(0, '0, 1, 1, 32'h0, 1, 2'd0);                // ghr = 01
    step(1, 32'h14, 1, 0, '0, 0, '0);
    // R3: aliased PCs share a row
    step(1, 32'hFFFF_FF17, 1, 0, '0, 0, '0);
    step(1, 32'h8000_0115, 1, 0, '0, 0, '0);
    // R7: stall the response, lookups must wait
    step(1, 32'h40, 0, 0, '0, 0, '0);
    for (int i = 0; i < 3; i++) step(1, 32'h80, 0, 0, '0, 0, '0);
    step(1, 32'h80, 1, 0, '0, 0, '0);
    // R8: lookup and resolve to the same row in one cycle
    step(1, 32'h24, 1, 1, 32'h24, 1, 2'd1);
    step(1, 32'h24, 1, 1, 32'h24, 1, 2'd3);
    step(0, '0, 1, 0, '0, 0, '0);
    // random traffic over a small set of rows so counters move
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] a, b;
      a = $urandom();
      b = $urandom();
      a[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      b[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      step($urandom_range(0, 3) != 0, a, $urandom_range(0, 3) != 0,
           $urandom_range(0, 1) == 1, b, $urandom_range(0, 2) != 0,
           HIST_W'($urandom()));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule